// File: doc/BRIEF.md
# RGB Sampling Channel Sequencer

This block decides which colour channel (red, green or blue) an image-sensor front end samples next. It also presents the gain word and the offset word that belong to that channel, so that the gain and offset stages downstream are always loaded with settings for the channel being converted. The converter sample clock and the data-phase sampling clock arrive as level inputs. They are sampled on the block clock, and only their rising edges act on the sequence.

There are three operating modes. In three-channel mode the sequence steps through all three colours in one of two orders, and it restarts at the first colour of that order whenever the data-phase clock rises. In two-channel mode the selection alternates between green and blue. In one-channel mode the selection is parked on a single colour, chosen by three select bits that are resolved by priority. A power-down input freezes the selection.

Top module: `rgb_chan_seq`

## Requirements
- R1: After reset the channel index `chan_o` reads red. Channel codes are red = 0, green = 1 and blue = 2. `gain_o` and `ofs_o` carry the red words.
- R2: In three-channel mode (`mode_i` = 2'b10 or 2'b11) with `rgb_order_i` = 1, each rising edge of `adc_clk_i` advances the channel one clock later in the order red, green, blue, then back to red.
- R3: With `rgb_order_i` = 0, three-channel mode advances in the order blue, green, red, then back to blue.
- R4: In three-channel mode a rising edge of `cds_clk_i` moves the channel to the first colour of the order (red, or blue when reversed). This takes precedence over a rising edge of `adc_clk_i` in the same clock.
- R5: A clock input that stays high produces no further action. Holding `adc_clk_i` high advances the channel only once, and holding `cds_clk_i` high restarts the sequence only once.
- R6: In one-channel mode (`mode_i` = 2'b00) the channel follows `one_sel_i`, where bit 0 selects red, bit 1 green and bit 2 blue. Priority runs red over green over blue, and red is used when no bit is set. Edges on either clock input do not move the selection.
- R7: In two-channel mode (`mode_i` = 2'b01) a rising edge of `adc_clk_i` moves green to blue and any other channel to green. A rising edge of `cds_clk_i` moves the channel to green and takes precedence.
- R8: While `pwr_dn_i` is 1 the channel index holds its value in every mode and for any clock edges or select changes. When `pwr_dn_i` returns to 0, normal sequencing resumes from the held channel.
- R9: `gain_o` and `ofs_o` equal the gain and offset inputs of the channel currently shown on `chan_o`, in the same cycle. A change to the selected channel's register value appears on the outputs without waiting for a channel change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_clk_i | input | 1 | Converter sample clock level, edge-detected |
| cds_clk_i | input | 1 | Data-phase sampling clock level, edge-detected |
| mode_i | input | 2 | 00 one-channel, 01 two-channel, 1x three-channel |
| rgb_order_i | input | 1 | 1 = red-green-blue order, 0 = blue-green-red |
| one_sel_i | input | 3 | One-channel select: bit 0 red, bit 1 green, bit 2 blue |
| pwr_dn_i | input | 1 | Freeze channel selection |
| gain_r_i | input | GAIN_W | Red gain word |
| gain_g_i | input | GAIN_W | Green gain word |
| gain_b_i | input | GAIN_W | Blue gain word |
| ofs_r_i | input | OFS_W | Red offset word |
| ofs_g_i | input | OFS_W | Green offset word |
| ofs_b_i | input | OFS_W | Blue offset word |
| chan_o | output | 2 | Selected channel index |
| gain_o | output | GAIN_W | Gain word of the selected channel |
| ofs_o | output | OFS_W | Offset word of the selected channel |

## Verification
The bench goes after five corner cases. The first is a restart edge that lands together with a sample edge; a design that let the sample edge win would land on green instead of the first colour. The second is a clock input held high across several cycles; a level-sensitive design would keep stepping or keep restarting. The third covers the wrap from the last colour back to the first in both orders, plus the case where two or all of the one-channel select bits are set or none are; a wrong priority would park on green or blue. The last two are power-down arriving mid-sequence with edges and select changes pending, which a careless design would let slip through, and a gain or offset change on the parked channel, which a design that registered the words only on channel changes would miss.

// File: rtl/chanseq_pkg.sv
package chanseq_pkg;

  localparam logic [1:0] CH_RED   = 2'd0;
  localparam logic [1:0] CH_GREEN = 2'd1;
  localparam logic [1:0] CH_BLUE  = 2'd2;

  localparam logic [1:0] MODE_ONE = 2'b00;
  localparam logic [1:0] MODE_TWO = 2'b01;

  // first colour of the three-channel sequence
  function automatic logic [1:0] seq_first(input logic rgb);
    return rgb ? CH_RED : CH_BLUE;
  endfunction

  // successor in the three-channel sequence, wrapping after the third colour
  function automatic logic [1:0] seq_next(input logic [1:0] cur, input logic rgb);
    logic [1:0] nxt;
    if (rgb) begin
      case (cur)
        CH_RED:   nxt = CH_GREEN;
        CH_GREEN: nxt = CH_BLUE;
        default:  nxt = CH_RED;
      endcase
    end else begin
      case (cur)
        CH_BLUE:  nxt = CH_GREEN;
        CH_GREEN: nxt = CH_RED;
        default:  nxt = CH_BLUE;
      endcase
    end
    return nxt;
  endfunction

  // one-channel select resolution: red over green over blue, red when empty
  function automatic logic [1:0] one_pick(input logic [2:0] sel);
    logic [1:0] pick;
    if (sel[0])      pick = CH_RED;
    else if (sel[1]) pick = CH_GREEN;
    else if (sel[2]) pick = CH_BLUE;
    else             pick = CH_RED;
    return pick;
  endfunction

endpackage

// File: rtl/chanseq_edge.sv
module chanseq_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] rise_o
);

  logic [N-1:0] prev_q;
  logic [N-1:0] prev_n;

  generate
    for (genvar i = 0; i < N; i++) begin : g_bit
      always_comb begin
        prev_n[i] = lvl_i[i];
        rise_o[i] = lvl_i[i] & ~prev_q[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q[i] <= 1'b0;
        else        prev_q[i] <= prev_n[i];
      end
    end
  endgenerate

endmodule

// File: rtl/chanseq_fsm.sv
module chanseq_fsm
  import chanseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_i,
  input  logic       rgb_i,
  input  logic [2:0] sel_i,
  input  logic       pd_i,
  input  logic       adc_rise_i,
  input  logic       cds_rise_i,
  output logic [1:0] chan_o
);

  logic [1:0] chan_q;
  logic [1:0] chan_n;
  logic       chan_en;
  logic       tri_mode;

  assign tri_mode = mode_i[1];
  assign chan_en  = ~pd_i;

  always_comb begin
    chan_n = chan_q;
    if (tri_mode) begin
      if (cds_rise_i)      chan_n = seq_first(rgb_i);
      else if (adc_rise_i) chan_n = seq_next(chan_q, rgb_i);
    end else if (mode_i == MODE_TWO) begin
      if (cds_rise_i)      chan_n = CH_GREEN;
      else if (adc_rise_i) chan_n = (chan_q == CH_GREEN) ? CH_BLUE : CH_GREEN;
    end else begin
      chan_n = one_pick(sel_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       chan_q <= CH_RED;
    else if (chan_en) chan_q <= chan_n;
  end

  assign chan_o = chan_q;

  // R4
  cds_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tri_mode && !pd_i && cds_rise_i) |=> (chan_q == ($past(rgb_i) ? CH_RED : CH_BLUE)));

  // R8
  pd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_i |=> $stable(chan_q));

  // R6
  one_red_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_ONE && !pd_i && sel_i[0]) |=> (chan_q == CH_RED));

  // R7
  two_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_TWO && !pd_i && !cds_rise_i && adc_rise_i && chan_q == CH_GREEN)
      |=> (chan_q == CH_BLUE));

  // R2
  chan_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chan_q != 2'd3);

endmodule

// File: rtl/chanseq_mux.sv
module chanseq_mux
  import chanseq_pkg::*;
#(
  parameter int W = 6
) (
  input  logic [1:0]   chan_i,
  input  logic [W-1:0] r_i,
  input  logic [W-1:0] g_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] word_o
);

  always_comb begin
    case (chan_i)
      CH_GREEN: word_o = g_i;
      CH_BLUE:  word_o = b_i;
      default:  word_o = r_i;
    endcase
  end

endmodule

// File: rtl/rgb_chan_seq.sv
module rgb_chan_seq
  import chanseq_pkg::*;
#(
  parameter int GAIN_W = 6,
  parameter int OFS_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_clk_i,
  input  logic              cds_clk_i,
  input  logic [1:0]        mode_i,
  input  logic              rgb_order_i,
  input  logic [2:0]        one_sel_i,
  input  logic              pwr_dn_i,
  input  logic [GAIN_W-1:0] gain_r_i,
  input  logic [GAIN_W-1:0] gain_g_i,
  input  logic [GAIN_W-1:0] gain_b_i,
  input  logic [OFS_W-1:0]  ofs_r_i,
  input  logic [OFS_W-1:0]  ofs_g_i,
  input  logic [OFS_W-1:0]  ofs_b_i,
  output logic [1:0]        chan_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic [OFS_W-1:0]  ofs_o
);

  localparam int NSTROBE = 2;
  localparam int IDX_ADC = 0;
  localparam int IDX_CDS = 1;

  logic [NSTROBE-1:0] lvl;
  logic [NSTROBE-1:0] rise;
  logic [1:0]         chan;

  assign lvl[IDX_ADC] = adc_clk_i;
  assign lvl[IDX_CDS] = cds_clk_i;

  chanseq_edge #(.N(NSTROBE)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (lvl),
    .rise_o (rise)
  );

  chanseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .rgb_i      (rgb_order_i),
    .sel_i      (one_sel_i),
    .pd_i       (pwr_dn_i),
    .adc_rise_i (rise[IDX_ADC]),
    .cds_rise_i (rise[IDX_CDS]),
    .chan_o     (chan)
  );

  chanseq_mux #(.W(GAIN_W)) u_gain_mux (
    .chan_i (chan),
    .r_i    (gain_r_i),
    .g_i    (gain_g_i),
    .b_i    (gain_b_i),
    .word_o (gain_o)
  );

  chanseq_mux #(.W(OFS_W)) u_ofs_mux (
    .chan_i (chan),
    .r_i    (ofs_r_i),
    .g_i    (ofs_g_i),
    .b_i    (ofs_b_i),
    .word_o (ofs_o)
  );

  assign chan_o = chan;

  // R5
  adc_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i[1] && !pwr_dn_i && adc_clk_i && $past(adc_clk_i) && !rise[IDX_CDS])
      |=> $stable(chan_o));

endmodule

// File: tb/rgb_chan_seq_bench.sv
module rgb_chan_seq_bench;

  localparam logic [1:0] R = 2'd0;
  localparam logic [1:0] G = 2'd1;
  localparam logic [1:0] B = 2'd2;

  typedef struct {
    logic [1:0] ch;
    logic [5:0] g;
    logic [8:0] o;
    string      tag;
  } exp_t;

  logic       clk;
  logic       rst_n;
  logic       adc, cds, rgb, pd;
  logic [1:0] mode;
  logic [2:0] sel;
  logic [5:0] gr, gg, gb;
  logic [8:0] orr, og, ob;
  logic [1:0] chan;
  logic [5:0] gain;
  logic [8:0] ofs;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;

  rgb_chan_seq u_rgb_chan_seq (
    .clk(clk), .rst_n(rst_n), .adc_clk_i(adc), .cds_clk_i(cds),
    .mode_i(mode), .rgb_order_i(rgb), .one_sel_i(sel), .pwr_dn_i(pd),
    .gain_r_i(gr), .gain_g_i(gg), .gain_b_i(gb),
    .ofs_r_i(orr), .ofs_g_i(og), .ofs_b_i(ob),
    .chan_o(chan), .gain_o(gain), .ofs_o(ofs)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [5:0] gain_of(input logic [1:0] c);
    return (c == G) ? gg : (c == B) ? gb : gr;
  endfunction

  function automatic logic [8:0] ofs_of(input logic [1:0] c);
    return (c == G) ? og : (c == B) ? ob : orr;
  endfunction

  task automatic step(input logic a, input logic c, input logic [1:0] e, input string tag);
    exp_t it;
    @(negedge clk); #1;
    adc = a; cds = c;
    @(posedge clk); #1;
    it.ch = e; it.g = gain_of(e); it.o = ofs_of(e); it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic cfg_wait();
    @(negedge clk); #1;
  endtask

  // monitor: compare at the negedge after each expected item is queued
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        checks++;
        if (chan !== it.ch) begin
          errors++;
          $display("FAIL %s: chan actual %0d expected %0d", it.tag, chan, it.ch);
        end else if (gain !== it.g || ofs !== it.o) begin
          errors++;
          $display("FAIL R9 (%s): gain/ofs actual %h/%h expected %h/%h",
                   it.tag, gain, ofs, it.g, it.o);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; adc = 0; cds = 0; mode = 2'b10; rgb = 1; sel = 3'b001; pd = 0;
    gr = 6'h11; gg = 6'h22; gb = 6'h33;
    orr = 9'h101; og = 9'h0a2; ob = 9'h1c3;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    step(0, 0, R, "R1 reset state");
    // R2 red-green-blue order with wrap
    step(1, 0, G, "R2 red->green");
    step(1, 0, G, "R5 adc held high");
    step(0, 0, G, "R2 adc low hold");
    step(1, 0, B, "R2 green->blue");
    step(0, 0, B, "R2 hold");
    step(1, 0, R, "R2 wrap blue->red");
    step(1, 0, R, "R5 no second advance");
    // R4 restart, precedence over adc edge
    step(0, 0, R, "R4 idle");
    step(1, 1, R, "R4 restart beats adc edge");
    step(0, 1, R, "R5 cds held");
    step(1, 1, G, "R5 cds held no restart");
    step(0, 0, G, "R4 idle");
    // R3 reversed order
    cfg_wait(); rgb = 0;
    step(0, 1, B, "R4 restart to blue");
    step(1, 0, G, "R3 blue->green");
    step(0, 0, G, "R3 hold");
    step(1, 0, R, "R3 green->red");
    step(0, 0, R, "R3 hold");
    step(1, 0, B, "R3 wrap red->blue");
    // R6 one-channel
    cfg_wait(); mode = 2'b00; sel = 3'b110;
    step(0, 0, G, "R6 green over blue");
    cfg_wait(); sel = 3'b111;
    step(0, 0, R, "R6 red over all");
    cfg_wait(); sel = 3'b000;
    step(0, 0, R, "R6 none -> red");
    cfg_wait(); sel = 3'b100;
    step(0, 0, B, "R6 blue only");
    step(1, 0, B, "R6 adc edge ignored");
    step(0, 1, B, "R6 cds edge ignored");
    // R7 two-channel
    cfg_wait(); mode = 2'b01;
    step(0, 0, B, "R7 hold");
    step(1, 0, G, "R7 blue->green");
    step(0, 0, G, "R7 hold");
    step(1, 0, B, "R7 green->blue");
    step(0, 0, B, "R7 hold");
    step(1, 0, G, "R7 blue->green");
    step(0, 0, G, "R7 hold");
    step(1, 1, G, "R7 cds beats adc");
    // R8 power-down
    cfg_wait(); pd = 1; mode = 2'b10; rgb = 1;
    step(0, 0, G, "R8 hold");
    step(1, 0, G, "R8 adc edge ignored");
    step(0, 1, G, "R8 cds edge ignored");
    cfg_wait(); mode = 2'b00; sel = 3'b100;
    step(0, 0, G, "R8 select ignored");
    cfg_wait(); pd = 0; mode = 2'b10;
    step(0, 0, G, "R8 resume hold");
    step(1, 0, B, "R8 resume advance");
    // R9 register change on parked channel
    cfg_wait(); gb = 6'h2c; ob = 9'h07e;
    step(0, 0, B, "R9 blue words update");
    cfg_wait(); gr = 6'h3f;
    step(1, 0, R, "R9 red words on wrap");

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule